// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block is the fetch-and-execute control unit of a small 8-bit accumulator core that runs 14-bit instruction words. It splits the oscillator clock into instruction cycles of four phases, Q1 to Q4. It fetches the next word during Q4 of the current cycle, so fetching overlaps execution. The word it fetches becomes the executing instruction at the following Q1. Inside each cycle it issues the strobes for the datapath: a register-file read in Q2, an ALU-result-valid marker in Q3, and a write to either the working register or the addressed file register in Q4.

An instruction decoder outside the block looks at the executing word. It returns a jump request with an 11-bit absolute target, a skip request for a conditional test that is true, and two flags: whether the word names a file register and whether it produces a result. When a jump or skip is taken, the prefetched word is thrown away and replaced by a NOP. The instruction therefore takes two cycles, and the second cycle does nothing. A jump loads the program counter with the target. A skip lets the counter keep stepping, so the word after the skipped one comes next.

Top module: `qcycle_seq`

## Requirements
- R1: The phase output steps 0,1,2,3 (Q1..Q4) once per clock and then repeats, so one instruction cycle is four clocks. `cyc_start` is high in Q1 and in no other phase.
- R2: While `rst` is high, the phase is held at Q1, the program counter at 0, and the instruction register at NOP (`ir_nop`=1, `ir_word`=0). The first instruction cycle after reset therefore executes a NOP.
- R3: `imem_rd` is high only in Q4, with `imem_addr` equal to the program counter. The word on `imem_rdata` is latched at the clock edge that ends Q4 and is the executing word (`ir_word`) for the whole of the next cycle.
- R4: With no taken request, the program counter rises by one per instruction cycle and wraps from 2^PC_W-1 to 0.
- R5: If `br_req` is high in Q4 of a non-NOP cycle, the program counter loads `br_tgt` and the prefetched word is replaced by a NOP. The target word executes in the cycle after that NOP.
- R6: If `skip_req` is high in Q4 of a non-NOP cycle, the prefetched word is replaced by a NOP and the counter keeps incrementing. The next word executed after a skip at address A is the one at A+2.
- R7: If `br_req` and `skip_req` are high together, the jump wins: the target executes after the NOP.
- R8: `br_req` and `skip_req` have no effect during a NOP cycle. A jump request held through the NOP that follows a jump does not add a second NOP.
- R9: In Q2 of a non-NOP cycle, `file_rd` is high whenever `op_uses_file` is high, even when `op_writes` is low or the result goes to the working register. `file_addr` carries `ir_word[6:0]`.
- R10: `alu_valid` is high in Q3 of every non-NOP cycle and at no other time.
- R11: In Q4 of a non-NOP cycle with `op_writes` high, `ir_word[7]`=0 raises `wreg_we`. `ir_word[7]`=1 raises `file_we`, provided `op_uses_file` is also high. `file_we` and `wreg_we` are never high together.
- R12: In a NOP cycle, `file_rd`, `alu_valid`, `file_we` and `wreg_we` all stay low, whatever the decoder flags say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W (11) | Program-memory address, equal to the program counter |
| imem_rd | output | 1 | Fetch strobe, high in Q4 |
| imem_rdata | input | IW (14) | Word returned by program memory for `imem_addr` |
| br_req | input | 1 | Decoded jump/call request for the executing word |
| skip_req | input | 1 | Decoded taken-skip request for the executing word |
| br_tgt | input | PC_W (11) | Absolute jump target |
| op_uses_file | input | 1 | Executing word names a file register |
| op_writes | input | 1 | Executing word produces a result |
| phase | output | 2 | Current phase, 0..3 for Q1..Q4 |
| cyc_start | output | 1 | High in Q1 |
| ir_word | output | IW (14) | Executing word, 0 during a NOP |
| ir_nop | output | 1 | Current cycle is a squashed NOP |
| file_addr | output | FA_W (7) | File-register address field of the executing word |
| file_rd | output | 1 | Register-file read strobe, Q2 |
| alu_valid | output | 1 | ALU result valid, Q3 |
| file_we | output | 1 | File-register write strobe, Q4 |
| wreg_we | output | 1 | Working-register write strobe, Q4 |

## Verification
Two redirect sources can arrive in the same Q4: the jump request and the skip request. The bench places both on the same word. It judges the result by the word that executes after the NOP: this must be the target, not the word two addresses on. A second same-cycle case pairs a NOP cycle with a jump request that is still active. The bench holds `br_req` high through the NOP that follows a jump and expects the target and its successor to run back to back, with no second NOP.

// File: rtl/qseq_pkg.sv
`timescale 1ns/1ps
package qseq_pkg;

    // Phase encoding within one instruction cycle.
    typedef enum logic [1:0] {
        QP1 = 2'd0,
        QP2 = 2'd1,
        QP3 = 2'd2,
        QP4 = 2'd3
    } qphase_e;

    localparam int unsigned NPHASE = 4;

    // Indices into the one-hot phase vector.
    localparam int unsigned HOT_Q1 = 0;
    localparam int unsigned HOT_Q2 = 1;
    localparam int unsigned HOT_Q3 = 2;
    localparam int unsigned HOT_Q4 = 3;

    // Kind of program-flow change resolved at the end of a cycle.
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_SKIP = 2'd1,
        RD_JUMP = 2'd2
    } redirect_e;

    // Per-phase control strobes for the datapath.
    typedef struct packed {
        logic cyc_start;
        logic fetch;
        logic file_rd;
        logic alu_valid;
        logic file_we;
        logic wreg_we;
    } strobe_t;

    function automatic qphase_e phase_after(qphase_e p);
        return qphase_e'(p + 2'd1);
    endfunction

    // A squashed cycle cannot redirect; a jump outranks a skip.
    function automatic redirect_e pick_redirect(logic squashed, logic jump, logic skip);
        if (squashed)  return RD_NONE;
        if (jump)      return RD_JUMP;
        if (skip)      return RD_SKIP;
        return RD_NONE;
    endfunction

endpackage

// File: rtl/qseq_phase.sv
`timescale 1ns/1ps
module qseq_phase
    import qseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output qphase_e           phase,
    output logic [NPHASE-1:0] phase_hot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= QP1;
        end else begin
            phase <= phase_after(phase);
        end
    end

    // One-hot decode of the phase counter.
    for (genvar i = 0; i < NPHASE; i++) begin : g_hot
        assign phase_hot[i] = (phase == 2'(i));
    end

endmodule

// File: rtl/qseq_pc.sv
`timescale 1ns/1ps
module qseq_pc
    import qseq_pkg::*;
#(
    parameter int unsigned PC_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  redirect_e       kind,
    input  logic [PC_W-1:0] tgt,
    output logic [PC_W-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (step) begin
            if (kind == RD_JUMP) begin
                pc <= tgt;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end

endmodule

// File: rtl/qseq_ireg.sv
`timescale 1ns/1ps
module qseq_ireg #(
    parameter int unsigned IW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          squash,
    input  logic [IW-1:0] fetch_word,
    output logic [IW-1:0] ir,
    output logic          nop
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ir  <= '0;
            nop <= 1'b1;
        end else if (load) begin
            nop <= squash;
            ir  <= squash ? '0 : fetch_word;
        end
    end

endmodule

// File: rtl/qseq_strobe.sv
`timescale 1ns/1ps
module qseq_strobe
    import qseq_pkg::*;
(
    input  logic [NPHASE-1:0] phase_hot,
    input  logic              nop,
    input  logic              uses_file,
    input  logic              writes,
    input  logic              dest_file,
    output strobe_t           st
);

    logic live;

    always_comb begin
        live         = ~nop;
        st.cyc_start = phase_hot[HOT_Q1];
        st.fetch     = phase_hot[HOT_Q4];
        st.file_rd   = phase_hot[HOT_Q2] & live & uses_file;
        st.alu_valid = phase_hot[HOT_Q3] & live;
        st.file_we   = phase_hot[HOT_Q4] & live & writes & uses_file & dest_file;
        st.wreg_we   = phase_hot[HOT_Q4] & live & writes & ~dest_file;
    end

endmodule

// File: rtl/qcycle_seq.sv
`timescale 1ns/1ps
module qcycle_seq
    import qseq_pkg::*;
#(
    parameter int unsigned IW       = 14,
    parameter int unsigned PC_W     = 11,
    parameter int unsigned FA_W     = 7,
    parameter int unsigned DEST_BIT = 7
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PC_W-1:0] imem_addr,
    output logic            imem_rd,
    input  logic [IW-1:0]   imem_rdata,
    input  logic            br_req,
    input  logic            skip_req,
    input  logic [PC_W-1:0] br_tgt,
    input  logic            op_uses_file,
    input  logic            op_writes,
    output logic [1:0]      phase,
    output logic            cyc_start,
    output logic [IW-1:0]   ir_word,
    output logic            ir_nop,
    output logic [FA_W-1:0] file_addr,
    output logic            file_rd,
    output logic            alu_valid,
    output logic            file_we,
    output logic            wreg_we
);

    qphase_e           cur_phase;
    logic [NPHASE-1:0] hot;
    redirect_e         kind;
    logic              squash_next;
    logic [PC_W-1:0]   pc;
    strobe_t           st;

    qseq_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .phase     (cur_phase),
        .phase_hot (hot)
    );

    always_comb begin
        kind        = pick_redirect(ir_nop, br_req, skip_req);
        squash_next = (kind != RD_NONE);
    end

    qseq_pc #(.PC_W(PC_W)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .step (hot[HOT_Q4]),
        .kind (kind),
        .tgt  (br_tgt),
        .pc   (pc)
    );

    qseq_ireg #(.IW(IW)) u_ireg (
        .clk        (clk),
        .rst        (rst),
        .load       (hot[HOT_Q4]),
        .squash     (squash_next),
        .fetch_word (imem_rdata),
        .ir         (ir_word),
        .nop        (ir_nop)
    );

    qseq_strobe u_strobe (
        .phase_hot (hot),
        .nop       (ir_nop),
        .uses_file (op_uses_file),
        .writes    (op_writes),
        .dest_file (ir_word[DEST_BIT]),
        .st        (st)
    );

    assign imem_addr = pc;
    assign imem_rd   = st.fetch;
    assign phase     = cur_phase;
    assign cyc_start = st.cyc_start;
    assign file_addr = ir_word[FA_W-1:0];
    assign file_rd   = st.file_rd;
    assign alu_valid = st.alu_valid;
    assign file_we   = st.file_we;
    assign wreg_we   = st.wreg_we;

endmodule

// File: rtl/qseq_checker.sv
`timescale 1ns/1ps
module qseq_checker #(
    parameter int unsigned PC_W = 11
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      phase,
    input logic            cyc_start,
    input logic            imem_rd,
    input logic [PC_W-1:0] imem_addr,
    input logic            ir_nop,
    input logic            br_req,
    input logic            skip_req,
    input logic [PC_W-1:0] br_tgt,
    input logic            file_rd,
    input logic            alu_valid,
    input logic            file_we,
    input logic            wreg_we
);

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase == 2'($past(phase) + 2'd1)); // R1

    AST_FETCH_THEN_START: assert property (@(posedge clk) disable iff (rst)
        imem_rd |=> cyc_start); // R3

    AST_PHASE_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cyc_start, file_rd, alu_valid, imem_rd})); // R1

    AST_PC_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd3) |=> $stable(imem_addr)); // R4

    AST_JUMP_LOADS_PC: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3 && !ir_nop && br_req) |=> imem_addr == $past(br_tgt)); // R5

    AST_TAKEN_SQUASHES: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3 && !ir_nop && (br_req || skip_req)) |=> ir_nop); // R6

    AST_NOP_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3 && ir_nop) |=> !ir_nop); // R8

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        ir_nop |-> !(file_rd || alu_valid || file_we || wreg_we)); // R12

    AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(file_we && wreg_we)); // R11

endmodule

bind qcycle_seq qseq_checker #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .cyc_start (cyc_start),
    .imem_rd   (imem_rd),
    .imem_addr (imem_addr),
    .ir_nop    (ir_nop),
    .br_req    (br_req),
    .skip_req  (skip_req),
    .br_tgt    (br_tgt),
    .file_rd   (file_rd),
    .alu_valid (alu_valid),
    .file_we   (file_we),
    .wreg_we   (wreg_we)
);

// File: tb/qcycle_seq_test.sv
`timescale 1ns/1ps
module qcycle_seq_test;

    localparam int IW   = 14;
    localparam int PC_W = 11;
    localparam int FA_W = 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] imem_addr;
    logic            imem_rd;
    logic [IW-1:0]   imem_rdata;
    logic            br_req, skip_req;
    logic [PC_W-1:0] br_tgt;
    logic            op_uses_file, op_writes;
    logic [1:0]      phase;
    logic            cyc_start;
    logic [IW-1:0]   ir_word;
    logic            ir_nop;
    logic [FA_W-1:0] file_addr;
    logic            file_rd, alu_valid, file_we, wreg_we;

    // Decoder model configuration
    logic            cfg_br_en = 1'b0, cfg_sk_en = 1'b0, cfg_nopbr = 1'b0;
    logic [PC_W-1:0] cfg_br_at = '0, cfg_sk_at = '0, cfg_tgt = '0;
    logic            cfg_file = 1'b1, cfg_wr = 1'b1;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [IW-1:0] word_at(logic [PC_W-1:0] a);
        return 14'h3000 | {3'b000, a};
    endfunction

    assign imem_rdata = word_at(imem_addr);

    always_comb begin
        br_req       = (cfg_br_en && !ir_nop && ir_word[PC_W-1:0] == cfg_br_at) || (cfg_nopbr && ir_nop);
        skip_req     = cfg_sk_en && !ir_nop && ir_word[PC_W-1:0] == cfg_sk_at;
        br_tgt       = cfg_tgt;
        op_uses_file = cfg_file;
        op_writes    = cfg_wr;
    end

    qcycle_seq uut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rd(imem_rd),
        .imem_rdata(imem_rdata), .br_req(br_req), .skip_req(skip_req),
        .br_tgt(br_tgt), .op_uses_file(op_uses_file), .op_writes(op_writes),
        .phase(phase), .cyc_start(cyc_start), .ir_word(ir_word), .ir_nop(ir_nop),
        .file_addr(file_addr), .file_rd(file_rd), .alu_valid(alu_valid),
        .file_we(file_we), .wreg_we(wreg_we)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic next_instr(output logic nop, output logic [IW-1:0] w);
        @(negedge clk);
        while (phase != 2'd0) @(negedge clk);
        nop = ir_nop;
        w   = ir_word;
    endtask

    task automatic expect_instr(string req, logic exp_nop, logic [PC_W-1:0] a);
        logic nop;
        logic [IW-1:0] w;
        next_instr(nop, w);
        check(req, "ir_nop", 32'(nop), 32'(exp_nop));
        check(req, "ir_word", 32'(w), exp_nop ? 32'd0 : 32'(word_at(a)));
    endtask

    // Starts at a Q1 sample point of a non-NOP cycle, ends at its Q4.
    task automatic check_strobes(string req, logic e_rd, logic e_fwe, logic e_wwe, logic [FA_W-1:0] e_fa);
        @(negedge clk);
        check(req, "phase Q2", 32'(phase), 32'd1);
        check(req, "file_rd Q2", 32'(file_rd), 32'(e_rd));
        check(req, "file_addr", 32'(file_addr), 32'(e_fa));
        @(negedge clk);
        check("R10", "alu_valid Q3", 32'(alu_valid), 32'd1);
        check(req, "file_rd Q3", 32'(file_rd), 32'd0);
        @(negedge clk);
        check(req, "file_we Q4", 32'(file_we), 32'(e_fwe));
        check(req, "wreg_we Q4", 32'(wreg_we), 32'(e_wwe));
        check("R3", "imem_rd Q4", 32'(imem_rd), 32'd1);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R2", "phase", 32'(phase), 32'd0);
        check("R2", "ir_nop", 32'(ir_nop), 32'd1);
        check("R2", "ir_word", 32'(ir_word), 32'd0);
        check("R2", "pc", 32'(imem_addr), 32'd0);
        check("R1", "cyc_start Q1", 32'(cyc_start), 32'd1);
        check("R3", "imem_rd Q1", 32'(imem_rd), 32'd0);
    endtask

    task automatic t_first_cycle();
        @(negedge clk);
        check("R1", "phase", 32'(phase), 32'd1);
        check("R1", "cyc_start Q2", 32'(cyc_start), 32'd0);
        check("R12", "file_rd in NOP", 32'(file_rd), 32'd0);
        @(negedge clk);
        check("R1", "phase", 32'(phase), 32'd2);
        check("R12", "alu_valid in NOP", 32'(alu_valid), 32'd0);
        @(negedge clk);
        check("R1", "phase", 32'(phase), 32'd3);
        check("R3", "imem_rd", 32'(imem_rd), 32'd1);
        check("R3", "imem_addr", 32'(imem_addr), 32'd0);
        check("R12", "writes in NOP", 32'(file_we | wreg_we), 32'd0);
        @(negedge clk);
        check("R1", "phase wrap", 32'(phase), 32'd0);
        check("R3", "ir_nop", 32'(ir_nop), 32'd0);
        check("R3", "ir_word", 32'(ir_word), 32'(word_at(11'd0)));
    endtask

    task automatic t_sequential();
        for (int i = 1; i <= 3; i++) expect_instr("R4", 1'b0, 11'(i));
        // word 3 has bit7=0: result to working register, file still read
        check_strobes("R11", 1'b1, 1'b0, 1'b1, 7'd3);
    endtask

    task automatic t_jump();
        expect_instr("R4", 1'b0, 11'd4);
        cfg_br_at = 11'd6; cfg_tgt = 11'h080; cfg_br_en = 1'b1;
        expect_instr("R4", 1'b0, 11'd5);
        expect_instr("R5", 1'b0, 11'd6);
        expect_instr("R5", 1'b1, 11'd0);
        expect_instr("R5", 1'b0, 11'h080);
        cfg_br_en = 1'b0;
        check_strobes("R11", 1'b1, 1'b1, 1'b0, 7'd0);
        expect_instr("R4", 1'b0, 11'h081);
        cfg_wr = 1'b0;
        check_strobes("R9", 1'b1, 1'b0, 1'b0, 7'd1);
        cfg_wr = 1'b1;
    endtask

    task automatic t_skip();
        cfg_sk_at = 11'h083; cfg_sk_en = 1'b1;
        expect_instr("R6", 1'b0, 11'h082);
        expect_instr("R6", 1'b0, 11'h083);
        expect_instr("R6", 1'b1, 11'd0);
        expect_instr("R6", 1'b0, 11'h085);
        cfg_sk_en = 1'b0;
    endtask

    task automatic t_both();
        cfg_br_at = 11'h086; cfg_sk_at = 11'h086; cfg_tgt = 11'h100;
        cfg_br_en = 1'b1; cfg_sk_en = 1'b1;
        expect_instr("R7", 1'b0, 11'h086);
        expect_instr("R7", 1'b1, 11'd0);
        expect_instr("R7", 1'b0, 11'h100);
        cfg_br_en = 1'b0; cfg_sk_en = 1'b0;
    endtask

    task automatic t_nop_ignore();
        cfg_br_at = 11'h101; cfg_tgt = 11'h300; cfg_br_en = 1'b1; cfg_nopbr = 1'b1;
        expect_instr("R8", 1'b0, 11'h101);
        expect_instr("R8", 1'b1, 11'd0);
        expect_instr("R8", 1'b0, 11'h300);
        cfg_nopbr = 1'b0; cfg_br_en = 1'b0;
        expect_instr("R8", 1'b0, 11'h301);
    endtask

    task automatic t_wrap();
        cfg_br_at = 11'h302; cfg_tgt = 11'h7FE; cfg_br_en = 1'b1;
        expect_instr("R5", 1'b0, 11'h302);
        expect_instr("R5", 1'b1, 11'd0);
        expect_instr("R4", 1'b0, 11'h7FE);
        cfg_br_en = 1'b0;
        expect_instr("R4", 1'b0, 11'h7FF);
        expect_instr("R4", 1'b0, 11'h000);
    endtask

    initial begin
        t_reset();
        t_first_cycle();
        t_sequential();
        t_jump();
        t_skip();
        t_both();
        t_nop_ignore();
        t_wrap();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule